// File: doc/BRIEF.md
# SDRAM Refresh Sequencer

This block keeps a four-bank SDRAM behind a registered memory module refreshed. A free-running interval counter produces one refresh obligation every 15.625 us of system clock, which is 4096 refreshes in 64 ms. When a refresh is owed, the block asks the command arbiter for the bus. Once granted, it closes any open rows with a single precharge-all, waits the row precharge time, issues one auto-refresh, then keeps the bus quiet for the row cycle time before handing it back.

A sleep request follows the same route to the bus but ends in self-refresh: the refresh pattern is issued with the clock enable falling, and the clock enable then stays low until the sleep request drops. On exit the clock enable rises with a no-operation, and the row cycle time is held off before the bus is released. If an owed refresh goes ungranted for eight intervals, a sticky error flag is raised.

The controller is a single state machine with nine states:
- `ST_IDLE`: nothing owed.
- `ST_REQ`: request raised, waiting for grant.
- `ST_PRE_ALL`: precharge-all issued.
- `ST_WAIT_RP`: row precharge wait.
- `ST_AREF`: auto-refresh issued.
- `ST_WAIT_RC`: row cycle hold-off.
- `ST_SR_ENTER`: self-refresh entry command.
- `ST_SELF_REF`: clock enable held low.
- `ST_SR_EXIT`: clock enable raised.

The transitions are:
- `ST_IDLE`→`ST_REQ` when a refresh is owed or sleep is requested.
- `ST_REQ`→`ST_IDLE` if both of those go away.
- `ST_REQ`→`ST_PRE_ALL` on grant with any bank open.
- `ST_REQ`→`ST_AREF` or `ST_SR_ENTER` on grant with all banks closed.
- `ST_PRE_ALL`→`ST_WAIT_RP`.
- `ST_WAIT_RP`→`ST_AREF` or `ST_SR_ENTER` once tRP has elapsed.
- `ST_AREF`→`ST_WAIT_RC`.
- `ST_SR_ENTER`→`ST_SELF_REF`.
- `ST_SELF_REF`→`ST_SR_EXIT` when sleep is released.
- `ST_SR_EXIT`→`ST_WAIT_RC`.
- `ST_WAIT_RC`→`ST_IDLE` once tRC has elapsed.

Top module: `refresh_scheduler`

## Requirements
- R1: While reset is held and in the first cycle after it, the outputs are cke=1 with a NOP on the bus (cs_n=0, ras_n=1, cas_n=1, we_n=1), and busy=0, req=0, ovf_err=0.
- R2: One refresh becomes owed every REF_PERIOD = floor(CLK_MHZ*15625/1000) clocks (1562 at 100 MHz). With grant held high and no sleep, consecutive auto-refresh commands are exactly REF_PERIOD cycles apart.
- R3: req rises one cycle after a refresh becomes owed, which is cycle REF_PERIOD+1 after reset. While req is high, busy is low and the bus carries NOP. A grant sampled with req high starts the sequence in the next cycle.
- R4: If any bank_open bit is set when the grant is sampled, the next cycle carries precharge-all: cs_n=0, ras_n=0, cas_n=1, we_n=0, a10=1.
- R5: If all bank_open bits are clear at the grant, no precharge is issued, and the refresh (or self-refresh entry) command appears in the cycle after the grant.
- R6: The refresh or self-refresh entry command follows a precharge-all by exactly TRP_CYC = max(2, ceil(TRP_NS*CLK_MHZ/1000)) cycles (2 at defaults), with NOP in between.
- R7: Auto-refresh is encoded as cs_n=0, ras_n=0, cas_n=0, we_n=1, with cke=1 in that cycle and in the cycle before.
- R8: After an auto-refresh, the bus carries NOP with busy high for TRC_CYC-1 cycles, and busy drops TRC_CYC cycles after the command. TRC_CYC = ceil(TRC_NS*CLK_MHZ/1000), at least TRP_CYC, which is 7 at defaults.
- R9: Every non-NOP command appears only while busy is high, and no encoding other than NOP, precharge-all, auto-refresh, self-refresh entry and the clock-enable-low idle ever appears.
- R10: On a sleep request, self-refresh entry is issued as the auto-refresh pattern with cke falling in that same cycle. cke then stays low with busy high and req low for as long as sleep_req stays high, however many refresh periods pass.
- R11: When sleep_req is seen low in self-refresh, cke returns high in the next cycle with a NOP. busy then stays high for TRC_CYC cycles in total and drops in the cycle after that.
- R12: If a refresh stays owed and ungranted for 8 further refresh ticks, ovf_err rises. With grant low from reset, this happens in cycle 9*REF_PERIOD. ovf_err stays high until reset, even after the refresh is later done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bank_open | input | BANKS | One bit per bank, set while a row is open |
| grant | input | 1 | Arbiter hands the command bus to this block |
| sleep_req | input | 1 | Request to enter and hold self-refresh |
| cke | output | 1 | Clock enable |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| a10 | output | 1 | Address bit 10, high selects all banks for precharge |
| req | output | 1 | Bus request to the arbiter |
| busy | output | 1 | Refresh or self-refresh sequence owns the bus |
| ovf_err | output | 1 | Sticky flag: refresh starved for eight intervals |

## Verification
The bench goes after the exact cycle counts of the sequence:
- The precharge-to-refresh gap: an off-by-one would issue the refresh one cycle early or late.
- The row-cycle hold-off: a short count would free the bus while the device is still busy.
- The refresh period: a miscounted reload drifts the spacing between refreshes.

It checks that a precharge is skipped only when every bank is closed, since a design that ignored the bank status would refresh with a row still open. It also checks that no periodic refresh leaks out during self-refresh, and that cke returns high on exit. Finally, it pins the starvation flag to the exact ninth tick and checks that it stays set after the late refresh, which catches a non-sticky flag or a miscounted age.

// File: rtl/refsched_pkg.sv
package refsched_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_REQ,
        ST_PRE_ALL,
        ST_WAIT_RP,
        ST_AREF,
        ST_WAIT_RC,
        ST_SR_ENTER,
        ST_SELF_REF,
        ST_SR_EXIT
    } rs_state_t;

    // Bit order: cke, cs_n, ras_n, cas_n, we_n, a10
    typedef struct packed {
        logic cke;
        logic cs_n;
        logic ras_n;
        logic cas_n;
        logic we_n;
        logic a10;
    } sdr_cmd_t;

    localparam sdr_cmd_t CMD_NOP     = 6'b101110;
    localparam sdr_cmd_t CMD_PRE_ALL = 6'b100101;
    localparam sdr_cmd_t CMD_REFRESH = 6'b100010;
    localparam sdr_cmd_t CMD_SR_IN   = 6'b000010;
    localparam sdr_cmd_t CMD_SR_HOLD = 6'b001110;

endpackage

// File: rtl/refsched_interval.sv
// Free-running refresh interval counter; one tick per period while run is high.
module refsched_interval #(
    parameter int PERIOD = 1562
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int CW = (PERIOD > 2) ? $clog2(PERIOD) : 1;
    localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run || cnt == LAST) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign tick = run && (cnt == LAST);
endmodule

// File: rtl/refsched_debt.sv
// Tracks an owed refresh and how many ticks it has gone ungranted.
module refsched_debt #(
    parameter int OVF_LIMIT = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic settle,
    input  logic waiting,
    output logic due,
    output logic err
);
    localparam int AW = $clog2(OVF_LIMIT + 1);
    localparam logic [AW-1:0] AGE_TRIP = AW'(OVF_LIMIT - 1);
    localparam logic [AW-1:0] AGE_MAX  = AW'(OVF_LIMIT);

    logic [AW-1:0] age;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            due <= 1'b0;
            age <= '0;
            err <= 1'b0;
        end else begin
            if (tick) begin
                due <= 1'b1;
            end else if (settle) begin
                due <= 1'b0;
            end

            if (settle || !waiting || !due) begin
                age <= '0;
            end else if (tick) begin
                if (age == AGE_TRIP) begin
                    err <= 1'b1;
                end
                if (age != AGE_MAX) begin
                    age <= age + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/refsched_delay.sv
// Saturating cycle counter restarted at each timed command.
module refsched_delay #(
    parameter int LIMIT = 7
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       start,
    output logic [$clog2(LIMIT+1)-1:0] count
);
    localparam int DW = $clog2(LIMIT + 1);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (start) begin
            count <= DW'(1);
        end else if (count != DW'(LIMIT)) begin
            count <= count + 1'b1;
        end
    end
endmodule

// File: rtl/refresh_scheduler.sv
module refresh_scheduler
    import refsched_pkg::*;
#(
    parameter int CLK_MHZ   = 100,
    parameter int TRP_NS    = 20,
    parameter int TRC_NS    = 70,
    parameter int OVF_LIMIT = 8,
    parameter int BANKS     = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [BANKS-1:0] bank_open,
    input  logic             grant,
    input  logic             sleep_req,
    output logic             cke,
    output logic             cs_n,
    output logic             ras_n,
    output logic             cas_n,
    output logic             we_n,
    output logic             a10,
    output logic             req,
    output logic             busy,
    output logic             ovf_err
);
    localparam int REF_PERIOD = (CLK_MHZ * 15625) / 1000;
    localparam int TRP_RAW    = (TRP_NS * CLK_MHZ + 999) / 1000;
    localparam int TRP_CYC    = (TRP_RAW < 2) ? 2 : TRP_RAW;
    localparam int TRC_RAW    = (TRC_NS * CLK_MHZ + 999) / 1000;
    localparam int TRC_CYC    = (TRC_RAW < TRP_CYC) ? TRP_CYC : TRC_RAW;
    localparam int DLY_W      = $clog2(TRC_CYC + 1);

    rs_state_t        state, nxt;
    logic             goal_sr;
    logic             tick, due, run, settle, waiting, dly_start;
    logic [DLY_W-1:0] dly;
    logic             rp_done, rc_done, any_open;
    sdr_cmd_t         cmd;

    assign any_open  = |bank_open;
    assign run       = !(state == ST_SR_ENTER || state == ST_SELF_REF);
    assign settle    = (state == ST_AREF) || (state == ST_SR_ENTER);
    assign waiting   = (state == ST_IDLE) || (state == ST_REQ);
    assign dly_start = (state == ST_PRE_ALL) || (state == ST_AREF) || (state == ST_SR_EXIT);
    assign rp_done   = (dly >= DLY_W'(TRP_CYC - 1));
    assign rc_done   = (dly >= DLY_W'(TRC_CYC - 1));

    refsched_interval #(.PERIOD(REF_PERIOD)) u_interval (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .tick  (tick)
    );

    refsched_debt #(.OVF_LIMIT(OVF_LIMIT)) u_debt (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .settle  (settle),
        .waiting (waiting),
        .due     (due),
        .err     (ovf_err)
    );

    refsched_delay #(.LIMIT(TRC_CYC)) u_delay (
        .clk   (clk),
        .rst_n (rst_n),
        .start (dly_start),
        .count (dly)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            goal_sr <= 1'b0;
        end else begin
            state <= nxt;
            if (state == ST_REQ && grant) begin
                goal_sr <= sleep_req;
            end
        end
    end

    // Next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:     if (due || sleep_req) nxt = ST_REQ;
            ST_REQ: begin
                if (!due && !sleep_req)  nxt = ST_IDLE;
                else if (grant) begin
                    if (any_open)        nxt = ST_PRE_ALL;
                    else if (sleep_req)  nxt = ST_SR_ENTER;
                    else                 nxt = ST_AREF;
                end
            end
            ST_PRE_ALL:  nxt = ST_WAIT_RP;
            ST_WAIT_RP:  if (rp_done) nxt = goal_sr ? ST_SR_ENTER : ST_AREF;
            ST_AREF:     nxt = ST_WAIT_RC;
            ST_WAIT_RC:  if (rc_done) nxt = ST_IDLE;
            ST_SR_ENTER: nxt = ST_SELF_REF;
            ST_SELF_REF: if (!sleep_req) nxt = ST_SR_EXIT;
            ST_SR_EXIT:  nxt = ST_WAIT_RC;
            default:     nxt = ST_IDLE;
        endcase
    end

    // Output decode
    always_comb begin
        cmd = CMD_NOP;
        unique case (state)
            ST_PRE_ALL:  cmd = CMD_PRE_ALL;
            ST_AREF:     cmd = CMD_REFRESH;
            ST_SR_ENTER: cmd = CMD_SR_IN;
            ST_SELF_REF: cmd = CMD_SR_HOLD;
            default:     cmd = CMD_NOP;
        endcase
    end

    assign cke   = cmd.cke;
    assign cs_n  = cmd.cs_n;
    assign ras_n = cmd.ras_n;
    assign cas_n = cmd.cas_n;
    assign we_n  = cmd.we_n;
    assign a10   = cmd.a10;
    assign req   = (state == ST_REQ);
    assign busy  = !waiting;
endmodule

// File: rtl/refresh_scheduler_chk.sv
module refresh_scheduler_chk (
    input logic clk,
    input logic rst_n,
    input logic cke,
    input logic cs_n,
    input logic ras_n,
    input logic cas_n,
    input logic we_n,
    input logic a10,
    input logic req,
    input logic busy,
    input logic ovf_err
);
    logic is_nop, is_pre, is_aref;
    assign is_nop  = !cs_n && ras_n && cas_n && we_n;
    assign is_pre  = cke && !cs_n && !ras_n && cas_n && !we_n && a10;
    assign is_aref = cke && !cs_n && !ras_n && !cas_n && we_n;

    assert_req_idle_bus_R3: assert property (@(posedge clk) disable iff (!rst_n)
        req |-> (!busy && is_nop && cke));

    assert_pre_then_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        is_pre |=> (is_nop && busy));

    assert_refresh_holdoff_R8: assert property (@(posedge clk) disable iff (!rst_n)
        is_aref |=> (is_nop && busy && cke));

    assert_cmd_needs_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && !is_nop) |-> busy);

    assert_cke_low_owned_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !cke |-> (busy && !req));

    assert_exit_nop_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cke) |-> (is_nop && busy));

    assert_no_overflow_clear_R12: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_err |=> ovf_err);
endmodule

bind refresh_scheduler refresh_scheduler_chk i_refresh_scheduler_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .cke     (cke),
    .cs_n    (cs_n),
    .ras_n   (ras_n),
    .cas_n   (cas_n),
    .we_n    (we_n),
    .a10     (a10),
    .req     (req),
    .busy    (busy),
    .ovf_err (ovf_err)
);

// File: tb/test_refresh_scheduler.sv
`timescale 1ns/1ps
module test_refresh_scheduler;
    localparam int CLK_MHZ = 100;
    localparam int PER     = (CLK_MHZ * 15625) / 1000;
    localparam int TRP     = 2;
    localparam int TRC     = 7;

    localparam logic [4:0] P_NOP  = 5'b10111;
    localparam logic [4:0] P_PRE  = 5'b10010;
    localparam logic [4:0] P_AREF = 5'b10001;
    localparam logic [4:0] P_SREN = 5'b00001;
    localparam logic [4:0] P_HOLD = 5'b00111;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] bank_open = 4'b0;
    logic       grant = 1'b0;
    logic       sleep_req = 1'b0;
    logic       cke, cs_n, ras_n, cas_n, we_n, a10, req, busy, ovf_err;

    int  n_cmp = 0;
    int  n_bad = 0;
    int  cyc = 0;
    bit  done = 1'b0;
    bit  spacing_en = 1'b0;
    int  last_aref = -1;
    int  pre_cyc = -1;
    int  rc_cyc = -1;
    logic prev_cke = 1'b1;

    always #10 clk = ~clk;

    refresh_scheduler i_refresh_scheduler (
        .clk(clk), .rst_n(rst_n), .bank_open(bank_open), .grant(grant),
        .sleep_req(sleep_req), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
        .cas_n(cas_n), .we_n(we_n), .a10(a10), .req(req), .busy(busy),
        .ovf_err(ovf_err)
    );

    function automatic logic [4:0] pins5();
        return {cke, cs_n, ras_n, cas_n, we_n};
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s at cycle %0d: actual %0h expected %0h", tag, cyc, act, exp);
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) cyc <= 0;
        else        cyc <= cyc + 1;
    end

    // Protocol monitor
    always @(negedge clk) begin
        if (!rst_n) begin
            last_aref = -1; pre_cyc = -1; rc_cyc = -1; prev_cke = 1'b1;
        end else begin
            logic [4:0] p;
            p = pins5();
            chk(p == P_NOP || p == P_PRE || p == P_AREF || p == P_SREN || p == P_HOLD,
                "R9 legal encoding", p, P_NOP);
            if (p != P_NOP) chk(busy == 1'b1, "R9 busy with command", busy, 1);
            if (p == P_PRE) begin
                chk(a10 == 1'b1, "R4 a10 on precharge", a10, 1);
                chk(rc_cyc < 0 || cyc - rc_cyc >= TRC, "R8 spacing before precharge", cyc - rc_cyc, TRC);
                pre_cyc = cyc;
            end
            if (p == P_AREF || p == P_SREN) begin
                chk(prev_cke == 1'b1, "R7 cke high before", prev_cke, 1);
                chk(bank_open == 4'b0, "R5 banks closed at refresh", bank_open, 0);
                chk(rc_cyc < 0 || cyc - rc_cyc >= TRC, "R8 spacing before refresh", cyc - rc_cyc, TRC);
                if (pre_cyc >= 0)
                    chk(cyc - pre_cyc == TRP, "R6 precharge to refresh gap", cyc - pre_cyc, TRP);
                pre_cyc = -1;
            end
            if (p == P_AREF) begin
                if (spacing_en && last_aref >= 0)
                    chk(cyc - last_aref == PER, "R2 refresh spacing", cyc - last_aref, PER);
                last_aref = cyc;
                rc_cyc = cyc;
            end
            if (cke && !prev_cke) rc_cyc = cyc;
            prev_cke = cke;
        end
    end

    task automatic reset_dut();
        rst_n = 1'b0; grant = 1'b0; sleep_req = 1'b0; bank_open = 4'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(pins5() == P_NOP && !busy && !req && !ovf_err, "R1 during reset",
            {pins5(), busy, req, ovf_err}, {P_NOP, 3'b000});
        rst_n = 1'b1;
        @(negedge clk);
        chk(pins5() == P_NOP && !busy && !req && !ovf_err, "R1 after reset",
            {pins5(), busy, req, ovf_err}, {P_NOP, 3'b000});
    endtask

    task automatic wait_cyc(input int n);
        while (cyc != n) @(negedge clk);
    endtask

    // Waits for req (grant already high) and checks the command sequence
    task automatic run_seq(input bit with_pre, input bit to_sr);
        while (!req) @(negedge clk);
        @(negedge clk);
        if (with_pre) begin
            chk(pins5() == P_PRE && a10, "R4 precharge after grant", pins5(), P_PRE);
            bank_open = 4'b0;
            repeat (TRP - 1) begin
                @(negedge clk);
                chk(pins5() == P_NOP && busy, "R6 quiet during tRP", pins5(), P_NOP);
            end
            @(negedge clk);
        end
        if (to_sr) begin
            chk(pins5() == P_SREN, "R10 self-refresh entry", pins5(), P_SREN);
        end else begin
            chk(pins5() == P_AREF, with_pre ? "R7 refresh after precharge" : "R5 refresh without precharge",
                pins5(), P_AREF);
            repeat (TRC - 1) begin
                @(negedge clk);
                chk(pins5() == P_NOP && busy, "R8 hold-off", {pins5(), busy}, {P_NOP, 1'b1});
            end
            @(negedge clk);
            chk(!busy, "R8 busy released", busy, 0);
        end
    endtask

    initial begin
        int unsigned seed_init;
        seed_init = $urandom(32'd20240611);
        // Directed: precharge path, then no-precharge path
        reset_dut();
        grant = 1'b1; bank_open = 4'b0101;
        run_seq(1'b1, 1'b0);
        run_seq(1'b0, 1'b0);

        // R2: spacing with grant held high
        reset_dut();
        grant = 1'b1; spacing_en = 1'b1;
        wait_cyc(4 * PER + 20);
        spacing_en = 1'b0;

        // R3 and R12: starvation
        reset_dut();
        wait_cyc(PER);
        chk(!req, "R3 no request before tick", req, 0);
        wait_cyc(PER + 1);
        chk(req && !busy && pins5() == P_NOP, "R3 request raised, bus idle",
            {req, busy}, 2'b10);
        wait_cyc(9 * PER - 1);
        chk(!ovf_err, "R12 no overflow before ninth tick", ovf_err, 0);
        wait_cyc(9 * PER);
        chk(ovf_err, "R12 overflow at ninth tick", ovf_err, 1);
        grant = 1'b1;
        run_seq(1'b0, 1'b0);
        chk(ovf_err, "R12 overflow sticky", ovf_err, 1);

        // R10 and R11: self-refresh
        reset_dut();
        grant = 1'b1; bank_open = 4'b1000; sleep_req = 1'b1;
        run_seq(1'b1, 1'b1);
        begin
            bit hold_ok;
            hold_ok = 1'b1;
            repeat (3000) begin
                @(negedge clk);
                if (cke || req || !busy) hold_ok = 1'b0;
            end
            chk(hold_ok, "R10 cke held low, no refresh", hold_ok, 1);
        end
        sleep_req = 1'b0;
        @(negedge clk);
        chk(pins5() == P_NOP && busy, "R11 exit cke high with NOP", {pins5(), busy}, {P_NOP, 1'b1});
        repeat (TRC - 1) begin
            @(negedge clk);
            chk(busy && pins5() == P_NOP, "R11 hold-off after exit", busy, 1);
        end
        @(negedge clk);
        chk(!busy, "R11 busy released", busy, 0);

        // Random traffic checked by the monitor
        reset_dut();
        begin
            int phase_left;
            phase_left = $urandom_range(2000, 6000);
            for (int i = 0; i < 40000; i++) begin
                @(negedge clk);
                if (pins5() == P_PRE) bank_open = 4'b0;
                else if (!busy && !req && $urandom_range(0, 7) == 0)
                    bank_open = 4'($urandom_range(0, 15));
                grant = ($urandom_range(0, 3) == 0);
                phase_left--;
                if (phase_left <= 0) begin
                    sleep_req = ~sleep_req;
                    phase_left = sleep_req ? $urandom_range(50, 1500) : $urandom_range(2000, 6000);
                end
            end
            sleep_req = 1'b0;
            repeat (20) @(negedge clk);
            chk(!ovf_err, "R12 no overflow under random grants", ovf_err, 0);
        end

        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule